// File: doc/BRIEF.md
# Speculative Load Address Table

This block tracks loads that were moved ahead of older stores which might write the same bytes. When such a load runs early, it records its destination register number, its byte address and its access size in a small associative table. Every store that executes afterwards is snooped against all live entries. A store whose byte range touches a recorded range kills that entry, which marks the early value as stale.

Before software uses the early value, it issues a check with the register number. The table answers hit or miss in the same cycle. A miss means the value has to be recomputed through the recovery path. A load that faulted raises no exception. It only makes sure that no live entry exists for its register, so the later check fails. A clear-all input empties the table in one cycle.

Only the insert port can be held off. `ins_ready` is low exactly while `clear_all` is high, and an insert offered in that cycle is not taken. The store snoop and the check port have no ready signal: they are accepted in every cycle in which their valid is high.

Top module: `spec_load_table`

## Requirements
- R1: After reset every entry is invalid, so any check misses. `ins_ready` is high whenever `clear_all` is low.
- R2: An accepted insert without fault, with no store in the same cycle, makes a check of that register tag in any later cycle hit until something removes the entry.
- R3: At most one live entry exists per tag. An insert whose tag matches a live entry overwrites that entry in place and takes no other slot.
- R4: A new tag goes into the lowest-numbered free slot. When no slot is free, the slot under a round-robin pointer is replaced. The pointer starts at slot 0 after reset and advances by one, with wrap, on each such replacement only.
- R5: A store with `st_valid` kills every live entry whose byte range overlaps the store's range. Ranges are half-open [addr, addr+bytes). The size code maps 0→1, 1→2, 2→4, 3→8 bytes. Ranges do not wrap past the top of the address space, and ranges that only touch each other do not overlap.
- R6: If an insert and a store happen in the same cycle with overlapping ranges, the inserted entry is left invalid. If their ranges do not overlap, the inserted entry is valid.
- R7: An accepted insert with `ins_fault` high creates no valid entry. It kills a live entry with the same tag if one exists, and it does not move the round-robin pointer.
- R8: `chk_hit` is combinational from `chk_valid` and `chk_tag`, reflects the table as of the start of the cycle, and is low when `chk_valid` is low.
- R9: A check with `chk_clear` that hits kills that entry at the clock edge. An insert of the same tag in the same cycle takes priority and leaves the new entry in place.
- R10: `clear_all` kills every entry in one cycle and overrides every other operation in that cycle. `ins_ready` is low during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_all | input | 1 | Invalidate all entries |
| ins_valid | input | 1 | Insert request from an early load |
| ins_ready | output | 1 | Insert accepted this cycle |
| ins_tag | input | TAG_W | Destination register number of the load |
| ins_addr | input | ADDR_W | Byte address of the load |
| ins_size | input | 2 | Size code of the load |
| ins_fault | input | 1 | The load faulted; do not create a valid entry |
| st_valid | input | 1 | Store snoop valid |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store size code |
| chk_valid | input | 1 | Check request |
| chk_tag | input | TAG_W | Register number to check |
| chk_clear | input | 1 | Kill the entry if the check hits |
| chk_hit | output | 1 | The speculative value is still good |

## Verification
The bench builds the table with its defaults: 16 entries, 7-bit tags and 64-bit addresses. Random tags are drawn from 24 values, more than there are slots, so the table fills up regularly and the round-robin replacement and its interaction with freed slots are exercised often. Addresses stay inside a 256-byte window, so partial overlaps, adjacent ranges and same-cycle insert/store collisions come up densely. One directed case sits at the very top of the 64-bit space to show that a range does not wrap onto address zero.

// File: rtl/spec_load_pkg.sv
package spec_load_pkg;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } acc_size_e;

  function automatic logic [3:0] span_bytes(input acc_size_e sz);
    return 4'd1 << sz;
  endfunction

endpackage

// File: rtl/spec_range_cmp.sv
module spec_range_cmp
  import spec_load_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] a_addr,
  input  acc_size_e         a_size,
  input  logic [ADDR_W-1:0] b_addr,
  input  acc_size_e         b_size,
  output logic              overlap
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

  // one extra bit keeps the end of the range from wrapping to zero
  always_comb begin
    a_lo    = {1'b0, a_addr};
    b_lo    = {1'b0, b_addr};
    a_hi    = a_lo + EXT_W'(span_bytes(a_size));
    b_hi    = b_lo + EXT_W'(span_bytes(b_size));
    overlap = (a_lo < b_hi) && (b_lo < a_hi);
  end
endmodule

// File: rtl/spec_victim_sel.sv
module spec_victim_sel #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [ENTRIES-1:0] tag_match,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   slot,
  output logic               matched,
  output logic               replace
);
  logic [IDX_W-1:0] free_idx, match_idx;
  logic             has_free;

  // scan from the top so the lowest index is kept last
  always_comb begin
    free_idx  = '0;
    match_idx = '0;
    has_free  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (tag_match[i]) match_idx = IDX_W'(i);
    end
    matched = |tag_match;
    replace = !matched && !has_free;
    if (matched)       slot = match_idx;
    else if (has_free) slot = free_idx;
    else               slot = rr_ptr;
  end
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import spec_load_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 7,
  parameter int ADDR_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [1:0]        ins_size,
  input  logic              ins_fault,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic              chk_clear,
  output logic              chk_hit
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  acc_size_e          size_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] ins_match, chk_match, st_hit;
  logic               ins_go, ins_clash;
  logic               vic_matched, vic_replace;
  logic [IDX_W-1:0]   vic_slot;

  assign ins_ready = !clear_all;
  assign ins_go    = ins_valid && ins_ready;
  assign chk_hit   = chk_valid && (|chk_match);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign ins_match[g] = vld_q[g] && (tag_q[g] == ins_tag);
    assign chk_match[g] = vld_q[g] && (tag_q[g] == chk_tag);

    spec_range_cmp #(.ADDR_W(ADDR_W)) u_snoop (
      .a_addr  (addr_q[g]),
      .a_size  (size_q[g]),
      .b_addr  (st_addr),
      .b_size  (acc_size_e'(st_size)),
      .overlap (st_hit[g])
    );
  end

  spec_range_cmp #(.ADDR_W(ADDR_W)) u_ins_vs_st (
    .a_addr  (ins_addr),
    .a_size  (acc_size_e'(ins_size)),
    .b_addr  (st_addr),
    .b_size  (acc_size_e'(st_size)),
    .overlap (ins_clash)
  );

  spec_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .vld       (vld_q),
    .tag_match (ins_match),
    .rr_ptr    (rr_q),
    .slot      (vic_slot),
    .matched   (vic_matched),
    .replace   (vic_replace)
  );

  // valid bits and replacement pointer; the insert is applied last and wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (clear_all) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if ((st_valid && st_hit[i]) || (chk_valid && chk_clear && chk_match[i]))
          vld_q[i] <= 1'b0;
      end
      if (ins_go) begin
        if (ins_fault) begin
          if (vic_matched) vld_q[vic_slot] <= 1'b0;
        end else begin
          vld_q[vic_slot] <= !(st_valid && ins_clash);
          if (vic_replace) rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
        end
      end
    end
  end

  // entry payload needs no reset: it is never used while its valid bit is low
  always_ff @(posedge clk) begin
    if (ins_go && !ins_fault) begin
      tag_q[vic_slot]  <= ins_tag;
      addr_q[vic_slot] <= ins_addr;
      size_q[vic_slot] <= acc_size_e'(ins_size);
    end
  end
endmodule

// File: rtl/spec_load_table_chk.sv
module spec_load_table_chk #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 7,
  parameter int ADDR_W  = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clear_all,
  input logic               ins_valid,
  input logic               ins_ready,
  input logic [TAG_W-1:0]   ins_tag,
  input logic [ADDR_W-1:0]  ins_addr,
  input logic [1:0]         ins_size,
  input logic               ins_fault,
  input logic               st_valid,
  input logic [ADDR_W-1:0]  st_addr,
  input logic [1:0]         st_size,
  input logic               chk_valid,
  input logic [TAG_W-1:0]   chk_tag,
  input logic               chk_clear,
  input logic               chk_hit,
  input logic [ENTRIES-1:0] tag_match
);
  logic            acc;
  logic [ADDR_W:0] i_lo, i_hi, s_lo, s_hi;
  logic            ovl;

  assign acc  = ins_valid && ins_ready;
  assign i_lo = {1'b0, ins_addr};
  assign s_lo = {1'b0, st_addr};
  assign i_hi = i_lo + ((ADDR_W + 1)'(1) << ins_size);
  assign s_hi = s_lo + ((ADDR_W + 1)'(1) << st_size);
  assign ovl  = (i_lo < s_hi) && (s_lo < i_hi);

  assert_insert_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ins_fault && !st_valid) |=> (!(chk_valid && chk_tag == $past(ins_tag)) || chk_hit));

  assert_unique_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tag_match));

  assert_collide_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ins_fault && st_valid && ovl) |=> (!(chk_valid && chk_tag == $past(ins_tag)) || !chk_hit));

  assert_fault_no_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ins_fault) |=> (!(chk_valid && chk_tag == $past(ins_tag)) || !chk_hit));

  assert_check_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_clear && chk_hit && !(acc && ins_tag == chk_tag))
      |=> (!(chk_valid && chk_tag == $past(chk_tag)) || !chk_hit));

  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> !chk_hit);
endmodule

bind spec_load_table spec_load_table_chk #(
  .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
  .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_tag(ins_tag),
  .ins_addr(ins_addr), .ins_size(ins_size), .ins_fault(ins_fault),
  .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
  .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_clear(chk_clear),
  .chk_hit(chk_hit), .tag_match(chk_match)
);

// File: tb/sim_spec_load_table.sv
module sim_spec_load_table;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clear_all, ins_valid, ins_fault, st_valid, chk_valid, chk_clear;
  logic        ins_ready, chk_hit;
  logic [6:0]  ins_tag, chk_tag;
  logic [63:0] ins_addr, st_addr;
  logic [1:0]  ins_size, st_size;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  // reference model of the table
  bit          m_vld  [N];
  logic [6:0]  m_tag  [N];
  logic [63:0] m_addr [N];
  logic [1:0]  m_size [N];
  int          m_rr;

  always #4 clk = ~clk;

  spec_load_table u0 (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_tag(ins_tag),
    .ins_addr(ins_addr), .ins_size(ins_size), .ins_fault(ins_fault),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_clear(chk_clear),
    .chk_hit(chk_hit)
  );

  function automatic bit ovl(logic [63:0] a, logic [1:0] sa, logic [63:0] b, logic [1:0] sb);
    logic [64:0] ae, be;
    ae = {1'b0, a} + (65'd1 << sa);
    be = {1'b0, b} + (65'd1 << sb);
    return ({1'b0, a} < be) && ({1'b0, b} < ae);
  endfunction

  function automatic bit m_lookup(logic [6:0] t);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit act, bit exp, string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    m_rr = 0;
  endtask

  task automatic model_apply();
    bit pre[N];
    int midx, fidx, slot;
    for (int i = 0; i < N; i++) pre[i] = m_vld[i];
    if (clear_all) begin
      for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
      return;
    end
    midx = -1;
    fidx = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (!pre[i]) fidx = i;
      if (pre[i] && m_tag[i] == ins_tag) midx = i;
    end
    for (int i = 0; i < N; i++) begin
      if (st_valid && pre[i] && ovl(m_addr[i], m_size[i], st_addr, st_size)) m_vld[i] = 1'b0;
      if (chk_valid && chk_clear && pre[i] && m_tag[i] == chk_tag) m_vld[i] = 1'b0;
    end
    if (ins_valid) begin
      if (ins_fault) begin
        if (midx >= 0) m_vld[midx] = 1'b0;
      end else begin
        if (midx >= 0) slot = midx;
        else if (fidx >= 0) slot = fidx;
        else begin
          slot = m_rr;
          m_rr = (m_rr + 1) % N;
        end
        m_vld[slot]  = !(st_valid && ovl(ins_addr, ins_size, st_addr, st_size));
        m_tag[slot]  = ins_tag;
        m_addr[slot] = ins_addr;
        m_size[slot] = ins_size;
      end
    end
  endtask

  task automatic idle();
    clear_all = 0; ins_valid = 0; ins_fault = 0; st_valid = 0;
    chk_valid = 0; chk_clear = 0;
    ins_tag = '0; chk_tag = '0; ins_addr = '0; st_addr = '0;
    ins_size = '0; st_size = '0;
  endtask

  // inputs are set at the falling edge; outputs are sampled 1 ns later
  task automatic tick();
    #1;
    if (chk_valid) check(chk_hit, m_lookup(chk_tag), "R8 model");
    else           check(chk_hit, 1'b0, "R8 idle");
    check(ins_ready, !clear_all, "R10 ready");
    @(posedge clk);
    model_apply();
    @(negedge clk);
    idle();
  endtask

  task automatic do_ins(logic [6:0] t, logic [63:0] a, logic [1:0] s, bit f);
    ins_valid = 1; ins_tag = t; ins_addr = a; ins_size = s; ins_fault = f;
    tick();
  endtask

  task automatic do_st(logic [63:0] a, logic [1:0] s);
    st_valid = 1; st_addr = a; st_size = s;
    tick();
  endtask

  task automatic expect_chk(logic [6:0] t, bit exp, string req);
    chk_valid = 1; chk_tag = t;
    #1;
    check(chk_hit, exp, req);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    idle();
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    for (int t = 0; t < 4; t++) expect_chk(7'(t), 1'b0, "R1");
    check(ins_ready, 1'b1, "R1 ready");

    // R2: insert then hit
    do_ins(7'd5, 64'h1000, 2'd3, 1'b0);
    expect_chk(7'd5, 1'b1, "R2");
    expect_chk(7'd6, 1'b0, "R2 other tag");

    // R5: touching range leaves entry, overlapping range kills it
    do_st(64'h1008, 2'd0);
    expect_chk(7'd5, 1'b1, "R5 adjacent");
    do_st(64'h0FFF, 2'd0);
    expect_chk(7'd5, 1'b1, "R5 adjacent below");
    do_st(64'h1007, 2'd1);
    expect_chk(7'd5, 1'b0, "R5 overlap");
    do_ins(7'd7, 64'hFFFF_FFFF_FFFF_FFF8, 2'd3, 1'b0);
    do_st(64'h0, 2'd3);
    expect_chk(7'd7, 1'b1, "R5 no wrap");

    // R6: same-cycle insert and store
    st_valid = 1; st_addr = 64'h2002; st_size = 2'd1;
    do_ins(7'd8, 64'h2000, 2'd2, 1'b0);
    expect_chk(7'd8, 1'b0, "R6 collide");
    st_valid = 1; st_addr = 64'h2004; st_size = 2'd2;
    do_ins(7'd9, 64'h2000, 2'd2, 1'b0);
    expect_chk(7'd9, 1'b1, "R6 disjoint");

    // R7: faulted load
    do_ins(7'd11, 64'h3000, 2'd0, 1'b1);
    expect_chk(7'd11, 1'b0, "R7 new tag");
    do_ins(7'd9, 64'h3000, 2'd0, 1'b1);
    expect_chk(7'd9, 1'b0, "R7 kills existing");

    // R9: check with clear, and insert priority
    expect_chk(7'd7, 1'b1, "R9 before");
    chk_valid = 1; chk_tag = 7'd7; chk_clear = 1;
    tick();
    expect_chk(7'd7, 1'b0, "R9 cleared");
    do_ins(7'd12, 64'h4000, 2'd0, 1'b0);
    chk_valid = 1; chk_tag = 7'd12; chk_clear = 1;
    do_ins(7'd12, 64'h4100, 2'd0, 1'b0);
    expect_chk(7'd12, 1'b1, "R9 insert wins");

    // R10: clear-all drops a concurrent insert
    clear_all = 1;
    do_ins(7'd13, 64'h5000, 2'd0, 1'b0);
    expect_chk(7'd12, 1'b0, "R10 cleared");
    expect_chk(7'd13, 1'b0, "R10 insert dropped");

    // R3 and R4: fill, overwrite, round robin, free-slot preference
    for (int i = 0; i < N; i++) do_ins(7'(10 + i), 64'(i * 16), 2'd3, 1'b0);
    do_ins(7'd13, 64'h900, 2'd3, 1'b0);
    do_ins(7'd40, 64'hA00, 2'd3, 1'b0);
    do_ins(7'd41, 64'hB00, 2'd3, 1'b0);
    expect_chk(7'd10, 1'b0, "R4 rr slot0");
    expect_chk(7'd11, 1'b0, "R4 rr slot1");
    expect_chk(7'd12, 1'b1, "R3 overwrite took no slot");
    expect_chk(7'd13, 1'b1, "R3 overwritten entry");
    expect_chk(7'd25, 1'b1, "R4 last slot kept");
    chk_valid = 1; chk_tag = 7'd20; chk_clear = 1;
    tick();
    do_ins(7'd42, 64'hC00, 2'd3, 1'b0);
    expect_chk(7'd12, 1'b1, "R4 free slot preferred");
    expect_chk(7'd42, 1'b1, "R4 new entry");

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      clear_all = ($urandom % 200) == 0;
      ins_valid = ($urandom % 10) < 4;
      ins_fault = ($urandom % 10) == 0;
      ins_tag   = 7'($urandom % 24);
      ins_addr  = 64'($urandom % 256);
      ins_size  = 2'($urandom);
      st_valid  = ($urandom % 10) < 3;
      st_addr   = 64'($urandom % 256);
      st_size   = 2'($urandom);
      chk_valid = ($urandom % 10) < 6;
      chk_tag   = 7'($urandom % 24);
      chk_clear = ($urandom % 10) < 3;
      tick();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule